// File: doc/BRIEF.md
# Replicated-Word Majority Voter with Trust Flag

This block sits after N identical copies of some logic, where N is odd (3, 5, 7 or 9). It receives each copy's W-bit result and returns one word in which every bit is decided by majority across the copies. It also raises a flag when the copies cannot be trusted. The block has no clock and no state. Its outputs follow its inputs within the same cycle.

The flag is based on agreement of whole words, not single bits. Every pair of copies is compared bit for bit. A group of Q = (N+1)/2 copies counts as agreeing when each neighbouring pair inside that group matches. The flag is the inverse of "some group agrees". The flag is therefore 1 whenever no Q copies carry the identical word, even if every bit position still has a clear majority. The block masks up to (N-1)/2 faulty copies.

The scheme has one accepted blind spot. If Q or more faulty copies produce the same wrong word, that wrong word wins the vote and the flag stays clear.

Top module: `nmr_voter`

## Requirements
- R1: Bit b of `voted` is 1 exactly when at least Q = (N+1)/2 copies carry 1 at bit b. Copy k occupies `rep_words[k*W +: W]`.
- R2: When all N copies carry the same word, `voted` equals that word and `untrusted` is 0.
- R3: When at least Q copies carry one identical word, `untrusted` is 0. This holds no matter what the remaining copies carry.
- R4: When no Q copies carry one identical word, `untrusted` is 1. An example is copies 0 and 1 matching while all the others differ from them and from each other.
- R5: Per-bit majority does not clear the flag. Suppose every bit position has a majority value, but no Q copies hold the same whole word. Then `voted` still shows the per-bit majority and `untrusted` is 1.
- R6: When Q faulty copies carry the same wrong word, `voted` equals that wrong word and `untrusted` is 0.
- R7: With at most (N-1)/2 copies faulty in any way, `voted` equals the word held by the correct copies.
- R8: The position of the agreeing group among the copy indices does not matter. A group made of the highest-numbered copies clears the flag just as a group of the lowest-numbered copies does.
- R9: Elaboration fails if N is even, below 3, or above 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rep_words | input | N*W | Results of the N copies. Copy k is at bits [k*W +: W]. |
| voted | output | W | Bitwise majority of the copies. |
| untrusted | output | 1 | 1 when no Q copies agree on every bit; 0 otherwise. |

## Verification
The first pattern has all copies identical. It shows that the flag stays clear and the word passes through unchanged. The next patterns place a Q-sized group of equal copies at low, mixed and high indices. These separate a correct subset search from one that only looks at leading copies, and they also cover the common-mode wrong-group case. Further patterns hold only a pair of matching copies, or give every bit a majority while all words are distinct. These show that the flag tracks whole-word agreement rather than per-bit voting. Finally, random vectors are biased toward copies of one base word. They reach every group size, and both outputs are compared with a bit-count majority and a search for Q identical copies.

// File: rtl/nmr_vote_pkg.sv
package nmr_vote_pkg;

  // number of set bits in a selection mask
  function automatic int ones(input int unsigned v);
    int c;
    c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  // index of the k-th set bit (counting from 0) of a selection mask
  function automatic int member(input int unsigned v, input int k);
    int seen;
    int idx;
    seen = 0;
    idx  = 0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) begin
        if (seen == k) idx = i;
        seen++;
      end
    end
    return idx;
  endfunction

endpackage

// File: rtl/word_match.sv
module word_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         same
);
  // per-bit equivalence, then AND across the word
  logic [W-1:0] bit_eq;
  assign bit_eq = a ~^ b;
  assign same   = &bit_eq;
endmodule

// File: rtl/group_agree.sv
module group_agree
  import nmr_vote_pkg::*;
#(
  parameter int N = 5
) (
  input  logic [N*N-1:0] pair_same,   // [i*N+j] valid for i<j
  output logic           any_group
);
  localparam int Q      = (N + 1) / 2;
  localparam int MASKS  = 1 << N;

  logic [MASKS-1:0] grp_ok;

  for (genvar m = 0; m < MASKS; m++) begin : g_mask
    if (ones(m) == Q) begin : g_sub
      logic [Q-2:0] links;
      for (genvar k = 0; k < Q - 1; k++) begin : g_link
        localparam int LO = member(m, k);
        localparam int HI = member(m, k + 1);
        assign links[k] = pair_same[LO*N + HI];
      end
      assign grp_ok[m] = &links;
    end else begin : g_none
      assign grp_ok[m] = 1'b0;
    end
  end

  assign any_group = |grp_ok;
endmodule

// File: rtl/bit_majority.sv
module bit_majority
  import nmr_vote_pkg::*;
#(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic [N*W-1:0] rep_words,
  output logic [W-1:0]   voted
);
  localparam int Q     = (N + 1) / 2;
  localparam int MASKS = 1 << N;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [N-1:0] column;
    for (genvar k = 0; k < N; k++) begin : g_col
      assign column[k] = rep_words[k*W + b];
    end
    // OR of all Q-sized products of this column
    always_comb begin
      voted[b] = 1'b0;
      for (int m = 0; m < MASKS; m++) begin
        if (ones(unsigned'(m)) == Q && ((column & N'(m)) == N'(m)))
          voted[b] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/nmr_voter.sv
module nmr_voter #(
  parameter int N = 5,
  parameter int W = 8
) (
  input  logic [N*W-1:0] rep_words,
  output logic [W-1:0]   voted,
  output logic           untrusted
);
  // R9
  if ((N % 2) == 0 || N < 3 || N > 9) begin : g_bad_n
    $error("nmr_voter: N must be odd and within 3..9");
  end

  logic [N*N-1:0] pair_same;
  logic           any_group;

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i < j) begin : g_cmp
        word_match #(.W(W)) u_match (
          .a    (rep_words[i*W +: W]),
          .b    (rep_words[j*W +: W]),
          .same (pair_same[i*N + j])
        );
      end else begin : g_off
        assign pair_same[i*N + j] = 1'b0;
      end
    end
  end

  group_agree #(.N(N)) u_groups (
    .pair_same (pair_same),
    .any_group (any_group)
  );

  bit_majority #(.N(N), .W(W)) u_vote (
    .rep_words (rep_words),
    .voted     (voted)
  );

  assign untrusted = ~any_group;
endmodule

// File: rtl/nmr_voter_chk.sv
module nmr_voter_chk #(
  parameter int N = 5,
  parameter int W = 8
) (
  input logic [N*W-1:0] rep_words,
  input logic [W-1:0]   voted,
  input logic           untrusted
);
  localparam int Q = (N + 1) / 2;

  int  best_group;
  int  cnt;
  int  col_ones;
  logic all_same;

  always_comb begin
    best_group = 0;
    for (int k = 0; k < N; k++) begin
      cnt = 0;
      for (int j = 0; j < N; j++)
        if (rep_words[j*W +: W] == rep_words[k*W +: W]) cnt++;
      if (cnt > best_group) best_group = cnt;
    end
    all_same = (best_group == N);

    for (int b = 0; b < W; b++) begin
      col_ones = 0;
      for (int k = 0; k < N; k++) col_ones += int'(rep_words[k*W + b]);
      // R1
      voted_bit_majority_chk: assert (voted[b] == (col_ones >= Q))
        else $error("voted bit %0d disagrees with column count", b);
    end

    // R2
    unanimous_pass_chk: assert (!all_same || (!untrusted && voted == rep_words[W-1:0]))
      else $error("unanimous copies not passed through cleanly");
    // R3
    group_clears_flag_chk: assert (best_group < Q || !untrusted)
      else $error("flag raised although a full group agrees");
    // R4
    no_group_sets_flag_chk: assert (best_group >= Q || untrusted)
      else $error("flag clear although no group agrees");
  end
endmodule

bind nmr_voter nmr_voter_chk #(.N(N), .W(W)) u_chk (
  .rep_words (rep_words),
  .voted     (voted),
  .untrusted (untrusted)
);

// File: tb/nmr_voter_tb.sv
module nmr_voter_tb;
  localparam int N          = 5;
  localparam int W          = 8;
  localparam int Q          = (N + 1) / 2;
  localparam int CLK_PERIOD = 10;

  logic           clk;
  logic           rst_n;
  logic [N*W-1:0] reps;
  logic [W-1:0]   voted;
  logic           untrusted;

  int checks;
  int fails;
  bit finished;

  nmr_voter #(.N(N), .W(W)) u_dut (
    .rep_words (reps),
    .voted     (voted),
    .untrusted (untrusted)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // reference: per-bit ones count
  function automatic logic [W-1:0] exp_vote(input logic [N*W-1:0] r);
    logic [W-1:0] v;
    for (int b = 0; b < W; b++) begin
      int c;
      c = 0;
      for (int k = 0; k < N; k++) if (r[k*W + b]) c++;
      v[b] = (c >= Q);
    end
    return v;
  endfunction

  // reference: search for Q copies with the same word
  function automatic logic exp_flag(input logic [N*W-1:0] r);
    for (int k = 0; k < N; k++) begin
      int c;
      c = 0;
      for (int j = 0; j < N; j++) if (r[j*W +: W] == r[k*W +: W]) c++;
      if (c >= Q) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic put(input int k, input logic [W-1:0] w);
    reps[k*W +: W] = w;
  endtask

  task automatic compare(input string vtag, input string ftag,
                         input logic [W-1:0] want_v, input logic want_f);
    checks++;
    if (voted !== want_v) begin
      fails++;
      $display("FAIL %s voted actual=%h expected=%h", vtag, voted, want_v);
    end
    checks++;
    if (untrusted !== want_f) begin
      fails++;
      $display("FAIL %s untrusted actual=%b expected=%b", ftag, untrusted, want_f);
    end
  endtask

  // drive on the falling edge, sample a quarter period later
  task automatic settle();
    #(CLK_PERIOD/4);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    checks = 0;
    fails = 0;
    finished = 1'b0;
    rst_n = 1'b0;
    reps  = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // R2 reset state: all zero copies
    @(negedge clk); settle();
    compare("R2", "R2", '0, 1'b0);

    // R2 unanimous non-zero word
    @(negedge clk);
    for (int k = 0; k < N; k++) put(k, 8'hC7);
    settle();
    compare("R2", "R2", 8'hC7, 1'b0);

    // R3 exactly Q equal at 0,1,3
    @(negedge clk);
    put(0, 8'h5A); put(1, 8'h5A); put(2, 8'h01); put(3, 8'h5A); put(4, 8'hF0);
    settle();
    compare("R1", "R3", exp_vote(reps), 1'b0);

    // R4 only copies 0 and 1 correct, rest pairwise distinct
    @(negedge clk);
    put(0, 8'h3C); put(1, 8'h3C); put(2, 8'h81); put(3, 8'h42); put(4, 8'h24);
    settle();
    compare("R1", "R4", exp_vote(reps), 1'b1);

    // R5 each bit has a majority but all words distinct
    @(negedge clk);
    put(0, 8'h11); put(1, 8'h12); put(2, 8'h14); put(3, 8'h18); put(4, 8'h10);
    settle();
    compare("R5", "R5", 8'h10, 1'b1);

    // R6 common-mode wrong group 2,3,4
    @(negedge clk);
    put(0, 8'h55); put(1, 8'h55); put(2, 8'hAA); put(3, 8'hAA); put(4, 8'hAA);
    settle();
    compare("R6", "R6", 8'hAA, 1'b0);

    // R7 two arbitrary faults masked
    @(negedge clk);
    put(0, 8'h3C); put(1, 8'hFF); put(2, 8'h3C); put(3, 8'h00); put(4, 8'h3C);
    settle();
    compare("R7", "R7", 8'h3C, 1'b0);

    // R8 agreeing group at highest indices
    @(negedge clk);
    put(0, 8'h01); put(1, 8'h02); put(2, 8'h99); put(3, 8'h99); put(4, 8'h99);
    settle();
    compare("R8", "R8", 8'h99, 1'b0);

    // R8 agreeing group at lowest indices
    @(negedge clk);
    put(0, 8'h66); put(1, 8'h66); put(2, 8'h66); put(3, 8'h80); put(4, 8'h08);
    settle();
    compare("R8", "R8", 8'h66, 1'b0);

    // R1/R3/R4 random vectors biased toward one base word
    for (int t = 0; t < 400; t++) begin
      logic [W-1:0] base;
      @(negedge clk);
      base = W'($urandom);
      for (int k = 0; k < N; k++)
        put(k, ($urandom % 2 == 0) ? base : W'($urandom));
      settle();
      compare("R1", exp_flag(reps) ? "R4" : "R3", exp_vote(reps), exp_flag(reps));
    end

    finish_run();
  end
endmodule